// File: doc/BRIEF.md
# Latching Status Register Group

This block is one group of a hierarchical status reporting system. A live vector of condition flags feeds an edge-triggered event register whose bits latch until software reads them, or until a global clear-all. A software-writable mask register selects which latched events count toward a single summary flag.

The summary flag of one instance is meant to drive one condition input of another instance. That lets small per-module groups (for example five fault flags per plug-in module) roll up into a wider parent group. The parent group can then be used as the quality-fault group or as the normal-activity group of the device. Bit meanings are assigned by the instantiating logic. The block only provides the latch, mask and summary mechanics. Bit positions marked unused by a parameter are forced to zero everywhere.

Top module: `stat_group`

## Requirements
- R1: After reset the latched events, the mask and the summary output are all zero.
- R2: `cond_q` equals `cond_in` ANDed with `USED_MASK` in the same cycle. It is combinational, has no read strobe and has no side effect on any register.
- R3: A 0-to-1 transition of a used condition bit between two consecutive clock edges sets the matching event bit at the second edge. A condition bit that stays high, or rises again while its event bit is already set, changes nothing.
- R4: A set event bit stays set when its condition bit falls. It clears only through `evt_rd` or `clr_all`.
- R5: While `evt_rd` is high, `evt_q` shows the latched events as they were before the clear. The register is zero after that edge, unless R7 applies.
- R6: `clr_all` high at a clock edge clears every event bit.
- R7: A rising condition bit at the same edge as `evt_rd` or `clr_all` is latched, and it remains set after the clear.
- R8: `mask_wr` loads `mask_wdata` ANDed with `USED_MASK` into the mask at the edge, and `mask_q` reads it back. `summary` is 1 exactly when some bit is set in both the events and the mask.
- R9: Bits outside `USED_MASK` read zero in `cond_q`, `evt_q` and `mask_q`, and they never latch.
- R10: When a child instance's `summary` drives a parent `cond_in` bit, an enabled child event appears as a latched parent event bit one edge after it sets `summary`. The parent event bit remains set after the child is read and cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_in | input | WIDTH | Live condition flags |
| mask_wr | input | 1 | Load strobe for the mask register |
| mask_wdata | input | WIDTH | New mask value |
| evt_rd | input | 1 | Read-and-clear strobe for the event register |
| clr_all | input | 1 | Global clear of the event register |
| cond_q | output | WIDTH | Masked live condition value |
| evt_q | output | WIDTH | Latched event value |
| mask_q | output | WIDTH | Mask readback |
| summary | output | 1 | OR of events ANDed with the mask |

## Verification
A wrong edge-detect history register shows up in three ways: a missing event bit, a duplicate latch after a read, or a bit latched only because a level was held. Any of these reaches `evt_q` at the very next edge. A clear that wins over a coincident rise loses that event permanently. The bench therefore samples the cycle right after each read or clear. A mask or summary error is visible the same cycle through `summary`. In a parent/child chain, the same error appears one edge later in the parent's event bits.

// File: rtl/stat_group.sv
module stat_group #(
  parameter int WIDTH = 16,
  parameter logic [WIDTH-1:0] USED_MASK = 16'h07FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cond_in,
  input  logic             mask_wr,
  input  logic [WIDTH-1:0] mask_wdata,
  input  logic             evt_rd,
  input  logic             clr_all,
  output logic [WIDTH-1:0] cond_q,
  output logic [WIDTH-1:0] evt_q,
  output logic [WIDTH-1:0] mask_q,
  output logic             summary
);

  logic [WIDTH-1:0] prev_r, evt_r, mask_r, rise;
  logic             wipe;

  assign cond_q  = cond_in & USED_MASK;
  assign rise    = cond_q & ~prev_r;
  assign wipe    = evt_rd | clr_all;
  assign evt_q   = evt_r;
  assign mask_q  = mask_r;
  assign summary = |(evt_r & mask_r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_r <= '0;
      evt_r  <= '0;
      mask_r <= '0;
    end else begin
      prev_r <= cond_q;
      evt_r  <= (wipe ? '0 : evt_r) | rise;
      if (mask_wr) mask_r <= mask_wdata & USED_MASK;
    end
  end

  assert_rise_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((evt_r & $past(rise)) == $past(rise)));

  assert_evt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wipe |=> ((evt_r & $past(evt_r)) == $past(evt_r)));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wipe && rise == '0) |=> (evt_r == '0));

  assert_mask_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_r == ($past(mask_wdata) & USED_MASK)));

  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_r | mask_r) & ~USED_MASK) == '0);

endmodule

// File: tb/stat_group_tb.sv
module stat_group_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] USED = 16'h07FF;
  localparam logic [4:0]  SUSED = 5'h1F;

  typedef struct {
    logic [15:0] cond, evt, mask;
    logic        sum;
    string       tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic [15:0] tb_cond = '0, wdata = '0;
  logic wr = 0, rd = 0, clr = 0;
  logic [4:0] s_cond = '0, s_wdata = '0;
  logic s_wr = 0, s_rd = 0;
  logic [15:0] cond_q, evt_q, mask_q, dut_cond;
  logic summary;
  logic [4:0] s_cq, s_eq, s_mq;
  logic s_sum;

  int checks = 0, fails = 0;
  exp_t q[$];
  logic [15:0] m_prev = '0, m_evt = '0, m_en = '0;
  logic [4:0]  ms_prev = '0, ms_evt = '0, ms_en = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign dut_cond = {tb_cond[15:4], s_sum, tb_cond[2:0]};

  stat_group #(.WIDTH(5), .USED_MASK(SUSED)) u_sub (
    .clk(clk), .rst_n(rst_n), .cond_in(s_cond), .mask_wr(s_wr),
    .mask_wdata(s_wdata), .evt_rd(s_rd), .clr_all(clr),
    .cond_q(s_cq), .evt_q(s_eq), .mask_q(s_mq), .summary(s_sum));

  stat_group u_dut (
    .clk(clk), .rst_n(rst_n), .cond_in(dut_cond), .mask_wr(wr),
    .mask_wdata(wdata), .evt_rd(rd), .clr_all(clr),
    .cond_q(cond_q), .evt_q(evt_q), .mask_q(mask_q), .summary(summary));

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] c, input logic w, input logic [15:0] wd,
                      input logic r, input logic cl, input logic [4:0] sc,
                      input logic sw, input logic [4:0] swd, input logic sr,
                      input string tag);
    logic [15:0] pc, rise;
    logic [4:0]  srise;
    exp_t e;
    @(negedge clk);
    tb_cond = c; wr = w; wdata = wd; rd = r; clr = cl;
    s_cond = sc; s_wr = sw; s_wdata = swd; s_rd = sr;
    #1;
    if (r) chk(evt_q, m_evt, {tag, " R5 pre-clear value"});
    pc = {c[15:4], |(ms_evt & ms_en), c[2:0]} & USED;
    rise = pc & ~m_prev;
    m_evt = ((r || cl) ? 16'h0 : m_evt) | rise;
    m_prev = pc;
    if (w) m_en = wd & USED;
    srise = sc & SUSED & ~ms_prev;
    ms_evt = ((sr || cl) ? 5'h0 : ms_evt) | srise;
    ms_prev = sc & SUSED;
    if (sw) ms_en = swd & SUSED;
    @(posedge clk);
    #1;
    e.cond = {c[15:4], |(ms_evt & ms_en), c[2:0]} & USED;
    e.evt = m_evt; e.mask = m_en; e.sum = |(m_evt & m_en); e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(cond_q, e.cond, {e.tag, " cond_q"});
        chk(evt_q, e.evt, {e.tag, " evt_q"});
        chk(mask_q, e.mask, {e.tag, " mask_q"});
        chk({15'h0, summary}, {15'h0, e.sum}, {e.tag, " summary"});
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        #1;
        chk(evt_q, 16'h0, "R1 reset evt");
        chk(mask_q, 16'h0, "R1 reset mask");
        chk({15'h0, summary}, 16'h0, "R1 reset summary");
        step(16'h0000, 1, 16'hFFFF, 0, 0, 5'h00, 0, 5'h00, 0, "R8 R9 mask write");
        step(16'h0041, 0, 16'h0, 0, 0, 5'h00, 0, 5'h00, 0, "R3 R2 rise");
        step(16'h0000, 0, 16'h0, 0, 0, 5'h00, 0, 5'h00, 0, "R4 fall holds");
        step(16'h0001, 0, 16'h0, 0, 0, 5'h00, 0, 5'h00, 0, "R3 re-rise ignored");
        step(16'hF800, 0, 16'h0, 0, 0, 5'h00, 0, 5'h00, 0, "R9 unused bits");
        step(16'h0200, 0, 16'h0, 1, 0, 5'h00, 0, 5'h00, 0, "R5 R7 read with rise");
        step(16'h0200, 0, 16'h0, 1, 0, 5'h00, 0, 5'h00, 0, "R5 read clears");
        step(16'h0200, 0, 16'h0, 0, 0, 5'h00, 0, 5'h00, 0, "R3 held level");
        step(16'h0600, 0, 16'h0, 0, 1, 5'h00, 0, 5'h00, 0, "R7 clear with rise");
        step(16'h0000, 0, 16'h0, 0, 1, 5'h00, 0, 5'h00, 0, "R6 clear all");
        step(16'h0002, 1, 16'h0004, 0, 0, 5'h00, 0, 5'h00, 0, "R8 masked off");
        step(16'h0002, 1, 16'h000E, 0, 0, 5'h00, 1, 5'h1F, 0, "R8 enable hit");
        step(16'h0002, 0, 16'h0, 0, 0, 5'h04, 0, 5'h00, 0, "R10 child rise");
        step(16'h0002, 0, 16'h0, 0, 0, 5'h04, 0, 5'h00, 0, "R10 parent latch");
        step(16'h0002, 0, 16'h0, 0, 0, 5'h00, 0, 5'h00, 1, "R10 child read");
        step(16'h0002, 0, 16'h0, 0, 0, 5'h00, 0, 5'h00, 0, "R10 parent holds");
        step(16'h0000, 0, 16'h0, 1, 0, 5'h00, 0, 5'h00, 0, "R5 final read");
        step(16'h0000, 0, 16'h0, 0, 0, 5'h00, 0, 5'h00, 0, "R1 idle");
        repeat (3) @(posedge clk);
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule